// File: doc/BRIEF.md
# GF(16) Inverter in Normal-Basis Encoding

This block computes the multiplicative inverse of an element of the 16-element finite field. Both the input and the result use a normal-basis encoding. In that encoding, rotating the input rotates the inverse by the same amount. Only one output bit therefore needs its own Boolean function. The other three bits come from the same function applied to cyclic rotations of the input.

Two bases are supported, and the `basisSel` input picks one of them at run time. The plain basis is built as a sum of products. The optimal basis is built only from two-input NAND and NOR gates plus shared input inverters, with no XOR gates.

Zero has no inverse and is mapped to zero. A build-time parameter can place a register on the output. When it is set, the result and its valid flag arrive one cycle after the input. When it is clear, the block is purely combinational from input to output.

Top module: `gf16_nb_inverter`

## Requirements
- R1: In both bases, input 4'b0000 gives 4'b0000 and the identity 4'b1111 gives 4'b1111.
- R2: In both bases, 4'b0101 and 4'b1010 are each other's inverse.
- R3: With `basisSel`=0 (plain basis), the map is: 1→3, 2→6, 3→1, 4→C, 6→2, 7→D, 8→9, 9→8, B→E, C→4, D→7, E→B (hex).
- R4: With `basisSel`=1 (optimal basis), the map is: 1→4, 2→8, 3→E, 4→1, 6→D, 7→9, 8→2, 9→7, B→C, C→B, D→6, E→3 (hex).
- R5: In both bases, rotating the input left by one bit (new bit0 = old bit3) rotates the output left by one bit.
- R6: In both bases, feeding the output back as input returns the original element.
- R7: With `REG_OUT`=1, `outElem` and `outValid` show the result and `inValid` sampled at the preceding rising clock edge, one cycle of latency.
- R8: With `REG_OUT`=1, a synchronous active-high `rst` clears `outValid` at the next rising edge, even while `inValid` is high.
- R9: With `REG_OUT`=0, `outElem` is the inverse of the present `inElem` and `outValid` equals `inValid` within the same cycle.
- R10: With `REG_OUT`=1, an edge with `inValid` low leaves `outElem` unchanged whatever `inElem` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| basisSel | input | 1 | 0 selects the plain basis, 1 selects the optimal basis |
| inValid | input | 1 | Input element is valid |
| inElem | input | 4 | Field element to invert |
| outValid | output | 1 | Result is valid |
| outElem | output | 4 | Inverse of the element |

## Verification
The bench builds two copies of the block side by side. One has `REG_OUT`=1, which makes the cycle of latency, the hold on idle edges and the mid-run reset visible. The other has `REG_OUT`=0, which allows a result to be read back within the same cycle. That makes it possible to chain two inversions, or to compare a rotated input against a rotated output, over all sixteen elements of both bases. Every input of both bases is compared against lookup tables written independently in the bench.

// File: rtl/gf16_nb_pkg.sv
package gf16_nb_pkg;
  localparam int NB_W = 4;
  typedef logic [NB_W-1:0] nbElem_t;

  typedef enum logic {
    BASIS_PLAIN   = 1'b0,
    BASIS_OPTIMAL = 1'b1
  } basis_e;

  typedef struct packed {
    logic captureEn;
    logic bypass;
  } nbStrobe_t;
endpackage

// File: rtl/gf16_nb_slice.sv
module gf16_nb_slice
  import gf16_nb_pkg::*;
(
  input  nbElem_t rotElem,
  input  nbElem_t rotInv,
  input  logic    basisSel,
  output logic    bitOut
);
  logic plainBit;
  logic optBit;

  // plain basis: sum of products selected by the two upper bits
  always_comb begin
    unique case (rotElem[3:2])
      2'b00:   plainBit = rotElem[0];
      2'b01:   plainBit = rotElem[0] & rotElem[1];
      2'b10:   plainBit = rotInv[0];
      default: plainBit = rotElem[0] | rotElem[1];
    endcase
  end

  // optimal basis: NAND/NOR network only
  logic gA, gB, gC, gD, gE, gEn, gX, gT;
  always_comb begin
    gA     = ~(rotElem[0] & rotInv[1]);
    gB     = ~(rotElem[2] & gA);
    gC     = ~(rotElem[2] | rotInv[3]);
    gD     = ~(rotElem[0] | rotElem[1]);
    gE     = ~(rotElem[0] & rotElem[1]);
    gEn    = ~gE;
    gX     = ~(gD | gEn);
    gT     = ~(gC & gX);
    optBit = ~(gB & gT);
  end

  assign bitOut = (basisSel == BASIS_OPTIMAL) ? optBit : plainBit;
endmodule

// File: rtl/gf16_nb_datapath.sv
module gf16_nb_datapath
  import gf16_nb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      basisSel,
  input  nbElem_t   inElem,
  input  nbStrobe_t strobe,
  output nbElem_t   outElem
);
  nbElem_t invX;
  nbElem_t invComb;
  nbElem_t heldElem;

  assign invX = ~inElem;

  for (genvar i = 0; i < NB_W; i++) begin : g_bit
    nbElem_t rotX;
    nbElem_t rotN;
    for (genvar k = 0; k < NB_W; k++) begin : g_rot
      assign rotX[k] = inElem[(k + i) % NB_W];
      assign rotN[k] = invX[(k + i) % NB_W];
    end
    gf16_nb_slice u_slice (
      .rotElem (rotX),
      .rotInv  (rotN),
      .basisSel(basisSel),
      .bitOut  (invComb[i])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.captureEn) heldElem <= invComb;
  end

  assign outElem = strobe.bypass ? invComb : heldElem;

  // R1
  zero_map_chk: assert property (@(posedge clk) disable iff (rst)
    (inElem == 4'b0000) |-> (invComb == 4'b0000));
  // R1
  unit_map_chk: assert property (@(posedge clk) disable iff (rst)
    (inElem == 4'b1111) |-> (invComb == 4'b1111));
  // R2
  order3_map_chk: assert property (@(posedge clk) disable iff (rst)
    (inElem == 4'b0101) |-> (invComb == 4'b1010));
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.captureEn && !strobe.bypass) |=> (outElem == $past(invComb)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.captureEn && !strobe.bypass) |=> $stable(outElem));
endmodule

// File: rtl/gf16_nb_ctrl.sv
module gf16_nb_ctrl
  import gf16_nb_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output nbStrobe_t strobe,
  output logic      outValid
);
  assign strobe.captureEn = inValid;
  assign strobe.bypass    = !REG_OUT;

  if (REG_OUT) begin : g_reg
    logic validQ;
    always_ff @(posedge clk) begin
      if (rst) validQ <= 1'b0;
      else     validQ <= inValid;
    end
    assign outValid = validQ;

    // R8
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> !outValid);
  end else begin : g_comb
    assign outValid = inValid;
  end

  // R7
  valid_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outValid == (REG_OUT ? $past(inValid) : inValid)));
endmodule

// File: rtl/gf16_nb_inverter.sv
module gf16_nb_inverter
  import gf16_nb_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       basisSel,
  input  logic       inValid,
  input  logic [3:0] inElem,
  output logic       outValid,
  output logic [3:0] outElem
);
  nbStrobe_t strobe;

  gf16_nb_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  gf16_nb_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .basisSel(basisSel),
    .inElem  (inElem),
    .strobe  (strobe),
    .outElem (outElem)
  );
endmodule

// File: tb/gf16_nb_inverter_bench.sv
module gf16_nb_inverter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic basisSel = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] inElem = 4'h0;
  logic regValid, combValid;
  logic [3:0] regOut, combOut;
  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gf16_nb_inverter #(.REG_OUT(1'b1)) u_gf16_nb_inverter (
    .clk(clk), .rst(rst), .basisSel(basisSel), .inValid(inValid),
    .inElem(inElem), .outValid(regValid), .outElem(regOut));

  gf16_nb_inverter #(.REG_OUT(1'b0)) u_gf16_nb_inverter_comb (
    .clk(clk), .rst(rst), .basisSel(basisSel), .inValid(inValid),
    .inElem(inElem), .outValid(combValid), .outElem(combOut));

  function automatic logic [3:0] refInv(logic sel, logic [3:0] x);
    if (!sel) begin
      case (x)
        4'h1: return 4'h3; 4'h2: return 4'h6; 4'h3: return 4'h1;
        4'h4: return 4'hC; 4'h5: return 4'hA; 4'h6: return 4'h2;
        4'h7: return 4'hD; 4'h8: return 4'h9; 4'h9: return 4'h8;
        4'hA: return 4'h5; 4'hB: return 4'hE; 4'hC: return 4'h4;
        4'hD: return 4'h7; 4'hE: return 4'hB; 4'hF: return 4'hF;
        default: return 4'h0;
      endcase
    end else begin
      case (x)
        4'h1: return 4'h4; 4'h2: return 4'h8; 4'h3: return 4'hE;
        4'h4: return 4'h1; 4'h5: return 4'hA; 4'h6: return 4'hD;
        4'h7: return 4'h9; 4'h8: return 4'h2; 4'h9: return 4'h7;
        4'hA: return 4'h5; 4'hB: return 4'hC; 4'hC: return 4'hB;
        4'hD: return 4'h6; 4'hE: return 4'h3; 4'hF: return 4'hF;
        default: return 4'h0;
      endcase
    end
  endfunction

  function automatic logic [3:0] rotl(logic [3:0] x);
    return {x[2:0], x[3]};
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic combApply(logic sel, logic [3:0] x, output logic [3:0] y);
    @(negedge clk);
    basisSel = sel;
    inElem = x;
    #1;
    y = combOut;
  endtask

  task automatic testResetState();
    @(negedge clk);
    check("R8 reset state", {3'b0, regValid}, 4'h0);
    rst = 1'b0;
  endtask

  task automatic testFixedPoints();
    logic [3:0] y;
    for (int s = 0; s < 2; s++) begin
      combApply(s[0], 4'h0, y); check("R1 zero", y, 4'h0);
      combApply(s[0], 4'hF, y); check("R1 identity", y, 4'hF);
      combApply(s[0], 4'h5, y); check("R2 0101", y, 4'hA);
      combApply(s[0], 4'hA, y); check("R2 1010", y, 4'h5);
    end
  endtask

  task automatic testFullMaps();
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 16; x++) begin
        @(negedge clk);
        basisSel = s[0];
        inElem = x[3:0];
        inValid = 1'b1;
        #1;
        check(s ? "R4 comb map" : "R3 comb map", combOut, refInv(s[0], x[3:0]));
        check("R9 comb valid", {3'b0, combValid}, 4'h1);
        @(posedge clk);
        #1;
        check(s ? "R4 reg map" : "R3 reg map", regOut, refInv(s[0], x[3:0]));
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R9 comb valid low", {3'b0, combValid}, 4'h0);
  endtask

  task automatic testRotation();
    logic [3:0] y0, y1;
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 16; x++) begin
        combApply(s[0], x[3:0], y0);
        combApply(s[0], rotl(x[3:0]), y1);
        check("R5 rotation", y1, rotl(y0));
      end
    end
  endtask

  task automatic testInvolution();
    logic [3:0] y, z;
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 16; x++) begin
        combApply(s[0], x[3:0], y);
        combApply(s[0], y, z);
        check("R6 involution", z, x[3:0]);
      end
    end
  endtask

  task automatic testLatency();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    basisSel = 1'b1;
    inElem = 4'h3;
    inValid = 1'b1;
    #1;
    check("R7 valid before edge", {3'b0, regValid}, 4'h0);
    @(posedge clk);
    #1;
    check("R7 valid after edge", {3'b0, regValid}, 4'h1);
    check("R7 data after edge", regOut, 4'hE);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R7 valid drops", {3'b0, regValid}, 4'h0);
  endtask

  task automatic testHold();
    @(negedge clk);
    basisSel = 1'b0;
    inElem = 4'h7;
    inValid = 1'b1;
    @(posedge clk);
    #1;
    check("R10 loaded", regOut, 4'hD);
    @(negedge clk);
    inValid = 1'b0;
    inElem = 4'h1;
    @(posedge clk);
    #1;
    check("R10 held", regOut, 4'hD);
    @(negedge clk);
    inElem = 4'hB;
    @(posedge clk);
    #1;
    check("R10 still held", regOut, 4'hD);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    inValid = 1'b1;
    inElem = 4'h2;
    @(posedge clk);
    #1;
    check("R8 valid before reset", {3'b0, regValid}, 4'h1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R8 reset clears valid", {3'b0, regValid}, 4'h0);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testResetState();
    testFixedPoints();
    testFullMaps();
    testRotation();
    testInvolution();
    testLatency();
    testHold();
    testMidReset();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #(20 * 150000);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule